// File: doc/BRIEF.md
# Banked Stack Pointer Controller

This block keeps the stack pointers of a processor core. It holds an exception stack pointer, a supervisor program stack pointer, a user program stack pointer and the user-mode flag. The user-mode flag selects which of the two program pointers serves push, pop and pop-with-return requests. Every stack grows toward lower addresses, and each entry is one data word. The block drives a simple synchronous memory port. Writes take effect at the clock edge. Read data arrives on the cycle after the request.

On an exception strobe, the block saves two words on the exception stack over two cycles: first the return address, then the status word. Bit 0 of the saved status word carries the mode that was active. The block then drops to supervisor mode. On an exception-return strobe, it pops the same two words back in reverse order over three cycles. It then hands the return address to the program counter, presents the restored status word, and reloads the mode from bit 0.

A jump-to-user command is the only way into user mode. A privileged load port lets supervisor code rewrite any pointer or the mode flag. In user mode, that load is refused and flagged.

Top module: `spb_ctrl`

## Requirements
- R1: After reset the exception, supervisor and user pointers equal their reset parameters, user mode is off, and busy, error, violation and all valid/load outputs are low.
- R2: A push accepted in supervisor mode writes push data at (supervisor pointer − 4) in the same cycle and lowers that pointer by 4. A pop reads at the pointer, raises it by 4, and shows the data with pop_valid_o one cycle later.
- R3: While user mode is on, program stack operations use and move only the user pointer; the supervisor pointer keeps its value.
- R4: A jump-to-user command sets user mode and, one cycle later, pulses pc_load_o with pc_o equal to the jump target.
- R5: An exception strobe writes the return address at (exception pointer − 4) in that cycle. In the next cycle, with busy_o high, it writes the status word at (exception pointer − 8), with bit 0 replaced by the mode that was active. The exception pointer ends 8 lower, and user mode is cleared.
- R6: An exception-return strobe reads the exception pointer, then that pointer + 4, with busy_o high for two cycles. In the second busy cycle it pulses pc_load_o with the second word and status_valid_o with the first word. User mode then equals bit 0 of the restored status word, and the exception pointer ends 8 higher.
- R7: A pop-with-return behaves as a pop and also pulses pc_load_o, with pc_o equal to the popped word, one cycle after the request.
- R8: The privileged load uses ld_sel_i encoding 0 = exception pointer, 1 = supervisor pointer, 2 = user pointer, 3 = mode flag from bit 0. It takes effect in supervisor mode. In user mode it changes nothing, and violation_o pulses one cycle later.
- R9: A push and a pop (or pop-with-return) in the same cycle perform the push only. proto_err_o pulses one cycle later and no pop data is signalled.
- R10: Only one command is taken per cycle, in the priority exception entry, exception return, jump-to-user, privileged load, then stack operations. Every command presented while busy_o is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| popret_i | input | 1 | Pop-with-return request |
| push_data_i | input | DW | Word to push |
| exc_enter_i | input | 1 | Exception entry strobe |
| exc_ret_addr_i | input | DW | Return address to save |
| exc_status_i | input | DW | Status word to save (bit 0 replaced by current mode) |
| exc_return_i | input | 1 | Exception return strobe |
| jusr_i | input | 1 | Jump-to-user command |
| jusr_target_i | input | DW | Jump target |
| ld_en_i | input | 1 | Privileged load strobe |
| ld_sel_i | input | 2 | Privileged load target select |
| ld_data_i | input | DW | Privileged load value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | DW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after request |
| pop_valid_o | output | 1 | Popped data valid |
| pop_data_o | output | DW | Popped data |
| pc_load_o | output | 1 | Program counter load pulse |
| pc_o | output | DW | Program counter load value |
| status_valid_o | output | 1 | Restored status valid |
| status_o | output | DW | Restored status word |
| user_mode_o | output | 1 | User mode flag |
| busy_o | output | 1 | Exception save/restore sequence in progress |
| proto_err_o | output | 1 | Push/pop clash pulse |
| violation_o | output | 1 | Refused privileged load pulse |
| isp_o | output | DW | Exception stack pointer |
| ssp_o | output | DW | Supervisor stack pointer |
| usp_o | output | DW | User stack pointer |

## Verification
The bench builds the block with a 32-bit word and pointer reset values of 0x100 (exception), 0x80 (supervisor) and 0xC0 (user). These values keep all three stacks inside a 64-word model memory. They also keep them far enough apart that a push through the wrong pointer lands at a visibly wrong address. Because 0x100 sits at the top of that memory, the two-word exception save lands at 0xFC and 0xF8. This lets the bench check the save order and the restore order through the memory port, and check the mode bit carried in the saved status word.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SAVE2 = 2'd1,
    SQ_REST2 = 2'd2,
    SQ_REST3 = 2'd3
  } seq_state_e;

  localparam logic [1:0] LSEL_ISP  = 2'd0;
  localparam logic [1:0] LSEL_SSP  = 2'd1;
  localparam logic [1:0] LSEL_USP  = 2'd2;
  localparam logic [1:0] LSEL_MODE = 2'd3;

  localparam int PTR_ISP = 0;
  localparam int PTR_SSP = 1;
  localparam int PTR_USP = 2;
  localparam int NUM_PTR = 3;

  localparam int MODE_BIT = 0;
endpackage

// File: rtl/spb_ptr_file.sv
module spb_ptr_file
  import spb_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] ISP_RST = 32'h0000_0100,
  parameter logic [31:0] SSP_RST = 32'h0000_0080,
  parameter logic [31:0] USP_RST = 32'h0000_00C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isp_dec,
  input  logic          isp_inc,
  input  logic          prog_dec,
  input  logic          prog_inc,
  input  logic          mode_clear,
  input  logic          mode_set,
  input  logic          mode_restore,
  input  logic          mode_restore_val,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] isp_o,
  output logic [DW-1:0] ssp_o,
  output logic [DW-1:0] usp_o,
  output logic [DW-1:0] active_o,
  output logic          user_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic [DW-1:0] ptr_q [NUM_PTR];
  logic [DW-1:0] ptr_d [NUM_PTR];
  logic [NUM_PTR-1:0] ptr_en;
  logic user_q, user_d, user_en;
  int unsigned act_idx;

  assign act_idx = user_q ? PTR_USP : PTR_SSP;

  always_comb begin
    for (int i = 0; i < NUM_PTR; i++) ptr_d[i] = ptr_q[i];
    ptr_en = '0;
    if (isp_dec) begin
      ptr_d[PTR_ISP]  = ptr_q[PTR_ISP] - STEP;
      ptr_en[PTR_ISP] = 1'b1;
    end else if (isp_inc) begin
      ptr_d[PTR_ISP]  = ptr_q[PTR_ISP] + STEP;
      ptr_en[PTR_ISP] = 1'b1;
    end
    if (prog_dec) begin
      ptr_d[act_idx]  = ptr_q[act_idx] - STEP;
      ptr_en[act_idx] = 1'b1;
    end else if (prog_inc) begin
      ptr_d[act_idx]  = ptr_q[act_idx] + STEP;
      ptr_en[act_idx] = 1'b1;
    end
    if (ld_en && ld_sel != LSEL_MODE) begin
      ptr_d[ld_sel]  = ld_data;
      ptr_en[ld_sel] = 1'b1;
    end
  end

  always_comb begin
    user_d  = user_q;
    user_en = 1'b0;
    if (mode_clear) begin
      user_d  = 1'b0;
      user_en = 1'b1;
    end else if (mode_set) begin
      user_d  = 1'b1;
      user_en = 1'b1;
    end else if (mode_restore) begin
      user_d  = mode_restore_val;
      user_en = 1'b1;
    end else if (ld_en && ld_sel == LSEL_MODE) begin
      user_d  = ld_data[MODE_BIT];
      user_en = 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    localparam logic [DW-1:0] RV = (g == PTR_ISP) ? DW'(ISP_RST) :
                                   (g == PTR_SSP) ? DW'(SSP_RST) : DW'(USP_RST);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= RV;
      else if (ptr_en[g]) q <= ptr_d[g];
    end
    assign ptr_q[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       user_q <= 1'b0;
    else if (user_en) user_q <= user_d;
  end

  assign isp_o    = ptr_q[PTR_ISP];
  assign ssp_o    = ptr_q[PTR_SSP];
  assign usp_o    = ptr_q[PTR_USP];
  assign active_o = ptr_q[act_idx];
  assign user_o   = user_q;

  // R2
  push_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_dec && !mode_clear && !mode_set && !mode_restore && !ld_en)
      |=> active_o == $past(active_o) - STEP);

  // R5
  exc_save_drops_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clear |=> !user_o);
endmodule

// File: rtl/spb_exc_seq.sv
module spb_exc_seq
  import spb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_save,
  input  logic          start_rest,
  input  logic [DW-1:0] save_word_i,
  input  logic [DW-1:0] rdata_i,
  output logic          busy_o,
  output logic          save2_o,
  output logic          rest2_o,
  output logic          rest3_o,
  output logic [DW-1:0] hold_o
);
  seq_state_e st_q, st_d;
  logic [DW-1:0] hold_q, hold_d;
  logic hold_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_save)      st_d = SQ_SAVE2;
        else if (start_rest) st_d = SQ_REST2;
      end
      SQ_SAVE2: st_d = SQ_IDLE;
      SQ_REST2: st_d = SQ_REST3;
      SQ_REST3: st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (st_q == SQ_IDLE && start_save) begin
      hold_d  = save_word_i;
      hold_en = 1'b1;
    end else if (st_q == SQ_REST2) begin
      hold_d  = rdata_i;
      hold_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign save2_o = (st_q == SQ_SAVE2);
  assign rest2_o = (st_q == SQ_REST2);
  assign rest3_o = (st_q == SQ_REST3);
  assign hold_o  = hold_q;

  // R5
  save_second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_save) |=> save2_o);

  // R6
  restore_three_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rest2_o |=> rest3_o);
endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl
  import spb_pkg::*;
#(
  parameter int          DW      = 32,
  parameter logic [31:0] ISP_RST = 32'h0000_0100,
  parameter logic [31:0] SSP_RST = 32'h0000_0080,
  parameter logic [31:0] USP_RST = 32'h0000_00C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          popret_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          exc_enter_i,
  input  logic [DW-1:0] exc_ret_addr_i,
  input  logic [DW-1:0] exc_status_i,
  input  logic          exc_return_i,
  input  logic          jusr_i,
  input  logic [DW-1:0] jusr_target_i,
  input  logic          ld_en_i,
  input  logic [1:0]    ld_sel_i,
  input  logic [DW-1:0] ld_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          pop_valid_o,
  output logic [DW-1:0] pop_data_o,
  output logic          pc_load_o,
  output logic [DW-1:0] pc_o,
  output logic          status_valid_o,
  output logic [DW-1:0] status_o,
  output logic          user_mode_o,
  output logic          busy_o,
  output logic          proto_err_o,
  output logic          violation_o,
  output logic [DW-1:0] isp_o,
  output logic [DW-1:0] ssp_o,
  output logic [DW-1:0] usp_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic busy, save2, rest2, rest3;
  logic [DW-1:0] hold, active_sp, save_word;
  logic user;

  // one command per cycle, fixed priority
  logic idle, take_exc, take_ret, take_jusr, take_ld, stack_ok;
  logic any_pop, take_push, take_pop, clash, ld_ok, ld_bad;

  assign idle      = !busy;
  assign take_exc  = idle && exc_enter_i;
  assign take_ret  = idle && !exc_enter_i && exc_return_i;
  assign take_jusr = idle && !exc_enter_i && !exc_return_i && jusr_i;
  assign take_ld   = idle && !exc_enter_i && !exc_return_i && !jusr_i && ld_en_i;
  assign stack_ok  = idle && !exc_enter_i && !exc_return_i && !jusr_i && !ld_en_i;
  assign any_pop   = pop_i || popret_i;
  assign take_push = stack_ok && push_i;
  assign take_pop  = stack_ok && any_pop && !push_i;
  assign clash     = stack_ok && push_i && any_pop;
  assign ld_ok     = take_ld && !user;
  assign ld_bad    = take_ld && user;

  always_comb begin
    save_word           = exc_status_i;
    save_word[MODE_BIT] = user;
  end

  spb_ptr_file #(
    .DW(DW), .ISP_RST(ISP_RST), .SSP_RST(SSP_RST), .USP_RST(USP_RST)
  ) u_ptrs (
    .clk             (clk),
    .rst_n           (rst_s_n),
    .isp_dec         (take_exc || save2),
    .isp_inc         (take_ret || rest2),
    .prog_dec        (take_push),
    .prog_inc        (take_pop),
    .mode_clear      (take_exc),
    .mode_set        (take_jusr),
    .mode_restore    (rest3),
    .mode_restore_val(hold[MODE_BIT]),
    .ld_en           (ld_ok),
    .ld_sel          (ld_sel_i),
    .ld_data         (ld_data_i),
    .isp_o           (isp_o),
    .ssp_o           (ssp_o),
    .usp_o           (usp_o),
    .active_o        (active_sp),
    .user_o          (user)
  );

  spb_exc_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start_save (take_exc),
    .start_rest (take_ret),
    .save_word_i(save_word),
    .rdata_i    (mem_rdata_i),
    .busy_o     (busy),
    .save2_o    (save2),
    .rest2_o    (rest2),
    .rest3_o    (rest3),
    .hold_o     (hold)
  );

  // memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (take_exc) begin
      mem_req_o = 1'b1; mem_we_o = 1'b1;
      mem_addr_o = isp_o - STEP; mem_wdata_o = exc_ret_addr_i;
    end else if (save2) begin
      mem_req_o = 1'b1; mem_we_o = 1'b1;
      mem_addr_o = isp_o - STEP; mem_wdata_o = hold;
    end else if (take_ret || rest2) begin
      mem_req_o = 1'b1;
      mem_addr_o = isp_o;
    end else if (take_push) begin
      mem_req_o = 1'b1; mem_we_o = 1'b1;
      mem_addr_o = active_sp - STEP; mem_wdata_o = push_data_i;
    end else if (take_pop) begin
      mem_req_o = 1'b1;
      mem_addr_o = active_sp;
    end
  end

  // one-cycle-late result flags
  logic pop_pend_q, ret_pend_q, jusr_pend_q, perr_q, viol_q;
  logic [DW-1:0] jtgt_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pop_pend_q  <= 1'b0;
      ret_pend_q  <= 1'b0;
      jusr_pend_q <= 1'b0;
      perr_q      <= 1'b0;
      viol_q      <= 1'b0;
    end else begin
      pop_pend_q  <= take_pop;
      ret_pend_q  <= take_pop && popret_i && !pop_i;
      jusr_pend_q <= take_jusr;
      perr_q      <= clash;
      viol_q      <= ld_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)       jtgt_q <= '0;
    else if (take_jusr) jtgt_q <= jusr_target_i;
  end

  assign pop_valid_o    = pop_pend_q;
  assign pop_data_o     = pop_pend_q ? mem_rdata_i : '0;
  assign pc_load_o      = ret_pend_q || jusr_pend_q || rest3;
  assign pc_o           = jusr_pend_q ? jtgt_q : (pc_load_o ? mem_rdata_i : '0);
  assign status_valid_o = rest3;
  assign status_o       = rest3 ? hold : '0;
  assign user_mode_o    = user;
  assign busy_o         = busy;
  assign proto_err_o    = perr_q;
  assign violation_o    = viol_q;

  // R8
  user_load_refused_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take_ld && user_mode_o) |=> ($stable(isp_o) && $stable(ssp_o) && $stable(usp_o)
                                  && user_mode_o && violation_o));

  // R9
  clash_flags_error_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy_o && push_i && (pop_i || popret_i) && !exc_enter_i && !exc_return_i
     && !jusr_i && !ld_en_i) |=> (proto_err_o && !pop_valid_o));

  // R10
  busy_blocks_program_sp_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_o && !rest3) |=> ($stable(ssp_o) && $stable(usp_o)));

  // R4
  jump_user_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy_o && jusr_i && !exc_enter_i && !exc_return_i) |=> (user_mode_o && pc_load_o));
endmodule

// File: tb/spb_ctrl_bench.sv
module spb_ctrl_bench;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic push_i, pop_i, popret_i, exc_enter_i, exc_return_i, jusr_i, ld_en_i;
  logic [DW-1:0] push_data_i, exc_ret_addr_i, exc_status_i, jusr_target_i, ld_data_i;
  logic [1:0] ld_sel_i;
  logic mem_req_o, mem_we_o;
  logic [DW-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic pop_valid_o, pc_load_o, status_valid_o, user_mode_o, busy_o, proto_err_o, violation_o;
  logic [DW-1:0] pop_data_o, pc_o, status_o, isp_o, ssp_o, usp_o;

  spb_ctrl #(.DW(DW), .ISP_RST(32'h100), .SSP_RST(32'h80), .USP_RST(32'hC0)) u_spb_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .pop_i(pop_i), .popret_i(popret_i), .push_data_i(push_data_i),
    .exc_enter_i(exc_enter_i), .exc_ret_addr_i(exc_ret_addr_i), .exc_status_i(exc_status_i),
    .exc_return_i(exc_return_i), .jusr_i(jusr_i), .jusr_target_i(jusr_target_i),
    .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o), .pc_load_o(pc_load_o), .pc_o(pc_o),
    .status_valid_o(status_valid_o), .status_o(status_o), .user_mode_o(user_mode_o),
    .busy_o(busy_o), .proto_err_o(proto_err_o), .violation_o(violation_o),
    .isp_o(isp_o), .ssp_o(ssp_o), .usp_o(usp_o)
  );

  // model memory: 64 words, read data one cycle after request
  logic [DW-1:0] mem [64];
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[7:2]];
    end
  end

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    push_i = 0; pop_i = 0; popret_i = 0; exc_enter_i = 0; exc_return_i = 0;
    jusr_i = 0; ld_en_i = 0; ld_sel_i = 0;
    push_data_i = 0; exc_ret_addr_i = 0; exc_status_i = 0; jusr_target_i = 0; ld_data_i = 0;
  endtask

  // kind (0 push, 1 pop), data, expected address, expected popped data
  localparam int NV = 8;
  localparam logic [97:0] VEC [NV] = '{
    {2'd0, 32'hA1, 32'h7C, 32'h0},
    {2'd0, 32'hB2, 32'h78, 32'h0},
    {2'd0, 32'hC3, 32'h74, 32'h0},
    {2'd1, 32'h0,  32'h74, 32'hC3},
    {2'd0, 32'hD4, 32'h74, 32'h0},
    {2'd1, 32'h0,  32'h74, 32'hD4},
    {2'd1, 32'h0,  32'h78, 32'hB2},
    {2'd1, 32'h0,  32'h7C, 32'hA1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 isp", isp_o, 32'h100);
    chk("R1 ssp", ssp_o, 32'h80);
    chk("R1 usp", usp_o, 32'hC0);
    chk("R1 flags", {28'd0, user_mode_o, busy_o, proto_err_o, pc_load_o}, 32'd0);

    // R2 vector table, supervisor stack
    for (int i = 0; i < NV; i++) begin
      logic [97:0] v;
      v = VEC[i];
      if (v[97:96] == 2'd0) begin push_i = 1; push_data_i = v[95:64]; end
      else pop_i = 1;
      #1;
      chk("R2 addr", mem_addr_o, v[63:32]);
      chk("R2 we", {31'd0, mem_we_o}, {31'd0, (v[97:96] == 2'd0)});
      tick();
      idle_inputs();
      if (v[97:96] == 2'd1) begin
        chk("R2 pop_valid", {31'd0, pop_valid_o}, 32'd1);
        chk("R2 pop_data", pop_data_o, v[31:0]);
      end
    end
    chk("R2 ssp back", ssp_o, 32'h80);

    // R9 push and pop together
    push_i = 1; pop_i = 1; push_data_i = 32'hE5;
    #1;
    chk("R9 addr", mem_addr_o, 32'h7C);
    tick();
    idle_inputs();
    chk("R9 err", {31'd0, proto_err_o}, 32'd1);
    chk("R9 no pop", {31'd0, pop_valid_o}, 32'd0);
    chk("R9 ssp", ssp_o, 32'h7C);
    tick();
    chk("R9 err one cycle", {31'd0, proto_err_o}, 32'd0);

    // R7 pop-with-return pops E5
    popret_i = 1;
    tick();
    idle_inputs();
    chk("R7 pc_load", {31'd0, pc_load_o}, 32'd1);
    chk("R7 pc", pc_o, 32'hE5);
    chk("R7 ssp", ssp_o, 32'h80);

    // R8 supervisor load of user pointer
    ld_en_i = 1; ld_sel_i = 2'd2; ld_data_i = 32'hB8;
    tick();
    idle_inputs();
    chk("R8 usp loaded", usp_o, 32'hB8);
    chk("R8 no violation", {31'd0, violation_o}, 32'd0);

    // R4 jump to user
    jusr_i = 1; jusr_target_i = 32'h4000;
    tick();
    idle_inputs();
    chk("R4 user", {31'd0, user_mode_o}, 32'd1);
    chk("R4 pc_load", {31'd0, pc_load_o}, 32'd1);
    chk("R4 pc", pc_o, 32'h4000);

    // R3 push in user mode
    push_i = 1; push_data_i = 32'h77;
    #1;
    chk("R3 addr", mem_addr_o, 32'hB4);
    tick();
    idle_inputs();
    chk("R3 usp", usp_o, 32'hB4);
    chk("R3 ssp kept", ssp_o, 32'h80);

    // R8 refused load in user mode
    ld_en_i = 1; ld_sel_i = 2'd3; ld_data_i = 32'h0;
    tick();
    idle_inputs();
    chk("R8 violation", {31'd0, violation_o}, 32'd1);
    chk("R8 mode kept", {31'd0, user_mode_o}, 32'd1);
    ld_en_i = 1; ld_sel_i = 2'd1; ld_data_i = 32'h40;
    tick();
    idle_inputs();
    chk("R8 ssp kept", ssp_o, 32'h80);

    // R5 exception entry from user mode
    exc_enter_i = 1; exc_ret_addr_i = 32'h5000; exc_status_i = 32'hAAAA_0000;
    #1;
    chk("R5 first addr", mem_addr_o, 32'hFC);
    chk("R5 first data", mem_wdata_o, 32'h5000);
    tick();
    idle_inputs();
    push_i = 1; push_data_i = 32'h66;
    #1;
    chk("R5 busy", {31'd0, busy_o}, 32'd1);
    chk("R5 user cleared", {31'd0, user_mode_o}, 32'd0);
    chk("R5 second addr", mem_addr_o, 32'hF8);
    chk("R5 second data", mem_wdata_o, 32'hAAAA_0001);
    tick();
    idle_inputs();
    chk("R5 isp", isp_o, 32'hF8);
    chk("R10 push dropped while busy", ssp_o, 32'h80);
    chk("R5 not busy", {31'd0, busy_o}, 32'd0);

    // R10 priority: exception return beats push; handler push first
    push_i = 1; push_data_i = 32'h99;
    #1;
    chk("R10 handler push addr", mem_addr_o, 32'h7C);
    tick();
    idle_inputs();
    pop_i = 1;
    tick();
    idle_inputs();
    chk("R10 handler pop", pop_data_o, 32'h99);

    // R6 exception return
    exc_return_i = 1; push_i = 1;
    #1;
    chk("R6 first addr", mem_addr_o, 32'hF8);
    tick();
    idle_inputs();
    chk("R10 push lost to return", ssp_o, 32'h80);
    chk("R6 busy", {31'd0, busy_o}, 32'd1);
    chk("R6 second addr", mem_addr_o, 32'hFC);
    tick();
    chk("R6 pc_load", {31'd0, pc_load_o}, 32'd1);
    chk("R6 pc", pc_o, 32'h5000);
    chk("R6 status_valid", {31'd0, status_valid_o}, 32'd1);
    chk("R6 status", status_o, 32'hAAAA_0001);
    tick();
    chk("R6 user restored", {31'd0, user_mode_o}, 32'd1);
    chk("R6 isp", isp_o, 32'h100);
    chk("R6 done", {31'd0, busy_o}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule